// File: doc/BRIEF.md
# CPU Bus Decoder with ROM Bank Register

This block sits beside an 8-bit CPU on a small video game board and turns each bus cycle into device selects. A memory cycle selects one of eight devices: a fixed program ROM, a 16 KB banked ROM window, work RAM, two palette byte RAMs (one for each half of a colour entry), two tile-code video RAMs and a colour-attribute RAM. For both ROM regions the block forms the physical ROM address. The banked window is steered by a 3-bit bank register that software loads with an I/O write.

An I/O cycle decodes only the low eight address bits. Reads return one of four configuration switch banks or one of three active-low player/coin input ports, and the block drives the CPU read data. Two adjacent I/O write addresses pulse the write enables for the address and data registers of the sound synthesiser. The I/O address that loads the bank register also serves as an input port when it is read. Any read that reaches no device returns 0xFF.

All decoding is combinational. The bank register is the only state, and a new bank takes effect on the cycle after the write edge.

Top module: `cpu_bus_decoder`

## Requirements
- R1: A qualified memory access to 0x0000-0x7FFF asserts `mem_cs[0]` (fixed ROM) and drives `rom_addr` equal to `cpu_addr`.
- R2: A qualified memory access to 0x8000-0xBFFF asserts `mem_cs[1]` (banked ROM) and drives `rom_addr` = 0x10000 + bank*0x4000 + (`cpu_addr` & 0x3FFF).
- R3: An I/O write whose address low byte is 0xA0 loads `wr_data[2:0]` into the bank register. Address bits 15:8 and data bits 7:3 play no part. The new bank is visible from the next clock cycle.
- R4: Synchronous reset clears the bank register to 0.
- R5: Memory selects: 0xC000-0xC7FF work RAM `mem_cs[2]`; 0xC800-0xCBFF palette byte A `mem_cs[3]`; 0xCC00-0xCFFF palette byte B `mem_cs[4]`; 0xD000-0xD7FF tile-low RAM `mem_cs[5]`; 0xD800-0xDFFF tile-high RAM `mem_cs[6]`; 0xE000-0xE7FF colour RAM `mem_cs[7]`.
- R6: A memory access is qualified when `mem_req`=1, `io_req`=0 and `rd` or `wr` is 1. `mem_cs` has at most one bit set. It is all zero for 0xE800-0xFFFF and whenever the access is not qualified. `rom_addr` is 0 outside the two ROM regions.
- R7: An I/O read at low byte 0x00, 0x20, 0x40 or 0x60 returns switch byte 0, 1, 2 or 3 in that order, where switch byte n is `dip_banks[8n+7:8n]`.
- R8: An I/O read at low byte 0x80, 0xA0 or 0xE0 returns input byte 0, 1 or 2 in that order, where input byte n is `key_ports[8n+7:8n]`, passed through unmodified.
- R9: An I/O write at low byte 0x40 asserts `snd_we[0]` (synth address) and one at 0x41 asserts `snd_we[1]` (synth data), for as long as the cycle lasts. Both are 0 otherwise.
- R10: `rd_data` equals `mem_rdata` on a qualified read of a mapped memory region. It is 0xFF on a read of unmapped memory, on a read of an unmapped I/O port (including 0x41 and 0xC0), and when no read is in progress.
- R11: Writes to unmapped I/O ports and memory writes at any address leave the bank register unchanged and raise no `snd_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| mem_req | input | 1 | Memory request strobe, active high |
| io_req | input | 1 | I/O request strobe, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| wr_data | input | 8 | CPU write data |
| mem_rdata | input | 8 | Read data returned by the selected memory device |
| dip_banks | input | 32 | Four switch bytes, byte n in bits 8n+7:8n |
| key_ports | input | 24 | Three active-low input bytes, byte n in bits 8n+7:8n |
| mem_cs | output | 8 | One-hot memory device selects |
| snd_we | output | 2 | Synth write enables: bit 0 address, bit 1 data |
| rom_addr | output | 18 | Physical ROM address |
| rd_data | output | 8 | Read data to the CPU |

## Verification
The bank register is the only place where state can go wrong. A bad register value appears as a wrong `rom_addr` on the first read of the banked window after the write. It then matches none of 0x10000 + n*0x4000 for the bank written. The bench therefore reads the window on the cycle after every bank-affecting write, including writes that must not change the bank. A decode error has no delay: a wrong or doubled `mem_cs`, or a stray `snd_we`, shows in the same cycle as the access.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    localparam int CPU_AW     = 16;
    localparam int DW         = 8;
    localparam int IO_AW      = 8;
    localparam int NUM_DIP    = 4;
    localparam int NUM_KEY    = 3;
    localparam int NUM_MEM_CS = 8;
    localparam int BANK_BITS  = 3;
    localparam int WIN_BITS   = 14;
    localparam int ROM_AW     = 18;
    localparam int BANK_BASE  = 32'h1_0000;

    localparam logic [DW-1:0] OPEN_BUS = '1;

    localparam logic [IO_AW-1:0] DIP_PORT [NUM_DIP] = '{8'h00, 8'h20, 8'h40, 8'h60};
    localparam logic [IO_AW-1:0] KEY_PORT [NUM_KEY] = '{8'h80, 8'hA0, 8'hE0};
    localparam logic [IO_AW-1:0] SND_ADDR_PORT = 8'h40;
    localparam logic [IO_AW-1:0] SND_DATA_PORT = 8'h41;
    localparam logic [IO_AW-1:0] BANK_PORT     = 8'hA0;

    // Region code n (n >= 1) drives select bit n-1.
    typedef enum logic [3:0] {
        RGN_NONE     = 4'd0,
        RGN_ROM_FIX  = 4'd1,
        RGN_ROM_WIN  = 4'd2,
        RGN_WORK     = 4'd3,
        RGN_PAL_A    = 4'd4,
        RGN_PAL_B    = 4'd5,
        RGN_TILE_LO  = 4'd6,
        RGN_TILE_HI  = 4'd7,
        RGN_COLOR    = 4'd8
    } region_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_any;
        logic io_rd;
        logic io_wr;
    } access_t;

    typedef struct packed {
        logic       hit;
        logic       is_key;
        logic [1:0] idx;
    } io_src_t;

    function automatic access_t qualify(input logic mreq, input logic ireq,
                                        input logic r, input logic w);
        access_t a;
        a.mem_any = mreq && !ireq && (r || w);
        a.mem_rd  = mreq && !ireq && r;
        a.io_rd   = ireq && !mreq && r;
        a.io_wr   = ireq && !mreq && w;
        return a;
    endfunction

    function automatic region_e decode_region(input logic [CPU_AW-1:0] a);
        region_e r;
        if (!a[15])                      r = RGN_ROM_FIX;
        else if (a[15:14] == 2'b10)      r = RGN_ROM_WIN;
        else if (a[15:11] == 5'b11000)   r = RGN_WORK;
        else if (a[15:10] == 6'b110010)  r = RGN_PAL_A;
        else if (a[15:10] == 6'b110011)  r = RGN_PAL_B;
        else if (a[15:11] == 5'b11010)   r = RGN_TILE_LO;
        else if (a[15:11] == 5'b11011)   r = RGN_TILE_HI;
        else if (a[15:11] == 5'b11100)   r = RGN_COLOR;
        else                             r = RGN_NONE;
        return r;
    endfunction

    function automatic logic [NUM_MEM_CS-1:0] region_sel(input region_e r);
        logic [NUM_MEM_CS-1:0] s;
        s = '0;
        for (int i = 0; i < NUM_MEM_CS; i++) begin
            if (r == region_e'(i + 1)) s[i] = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/busdec_mem_decode.sv
module busdec_mem_decode
    import busdec_pkg::*;
(
    input  logic [CPU_AW-1:0]     addr,
    input  logic                  qualified,
    output region_e               region,
    output logic [NUM_MEM_CS-1:0] cs
);
    region_e raw;

    always_comb begin
        raw    = decode_region(addr);
        region = qualified ? raw : RGN_NONE;
        cs     = region_sel(region);
    end
endmodule

// File: rtl/busdec_io_decode.sv
module busdec_io_decode
    import busdec_pkg::*;
(
    input  logic [IO_AW-1:0] port,
    input  logic             rd_ok,
    input  logic             wr_ok,
    output io_src_t          src,
    output logic [1:0]       snd_we,
    output logic             bank_we
);
    always_comb begin
        src = '0;
        if (rd_ok) begin
            for (int i = 0; i < NUM_DIP; i++) begin
                if (port == DIP_PORT[i]) begin
                    src.hit    = 1'b1;
                    src.is_key = 1'b0;
                    src.idx    = 2'(i);
                end
            end
            for (int k = 0; k < NUM_KEY; k++) begin
                if (port == KEY_PORT[k]) begin
                    src.hit    = 1'b1;
                    src.is_key = 1'b1;
                    src.idx    = 2'(k);
                end
            end
        end
        snd_we[0] = wr_ok && (port == SND_ADDR_PORT);
        snd_we[1] = wr_ok && (port == SND_DATA_PORT);
        bank_we   = wr_ok && (port == BANK_PORT);
    end
endmodule

// File: rtl/busdec_bank_reg.sv
module busdec_bank_reg #(
    parameter int BITS = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [BITS-1:0] d,
    output logic [BITS-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/busdec_rom_addr.sv
module busdec_rom_addr
    import busdec_pkg::*;
(
    input  region_e               region,
    input  logic [CPU_AW-1:0]     addr,
    input  logic [BANK_BITS-1:0]  bank,
    output logic [ROM_AW-1:0]     rom_addr
);
    localparam logic [ROM_AW-1:0] BASE = ROM_AW'(BANK_BASE);

    logic [ROM_AW-1:0] win_off;
    logic [ROM_AW-1:0] bank_off;

    always_comb begin
        win_off  = ROM_AW'(addr[WIN_BITS-1:0]);
        bank_off = ROM_AW'(bank) << WIN_BITS;
        unique case (region)
            RGN_ROM_FIX: rom_addr = ROM_AW'(addr);
            RGN_ROM_WIN: rom_addr = BASE + bank_off + win_off;
            default:     rom_addr = '0;
        endcase
    end
endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
    import busdec_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CPU_AW-1:0]        cpu_addr,
    input  logic                     mem_req,
    input  logic                     io_req,
    input  logic                     rd,
    input  logic                     wr,
    input  logic [DW-1:0]            wr_data,
    input  logic [DW-1:0]            mem_rdata,
    input  logic [NUM_DIP*DW-1:0]    dip_banks,
    input  logic [NUM_KEY*DW-1:0]    key_ports,
    output logic [NUM_MEM_CS-1:0]    mem_cs,
    output logic [1:0]               snd_we,
    output logic [ROM_AW-1:0]        rom_addr,
    output logic [DW-1:0]            rd_data
);
    access_t              acc;
    region_e              region;
    io_src_t              io_src;
    logic                 bank_we;
    logic [BANK_BITS-1:0] bank_q;

    assign acc = qualify(mem_req, io_req, rd, wr);

    busdec_mem_decode u_mem (
        .addr      (cpu_addr),
        .qualified (acc.mem_any),
        .region    (region),
        .cs        (mem_cs)
    );

    busdec_io_decode u_io (
        .port    (cpu_addr[IO_AW-1:0]),
        .rd_ok   (acc.io_rd),
        .wr_ok   (acc.io_wr),
        .src     (io_src),
        .snd_we  (snd_we),
        .bank_we (bank_we)
    );

    busdec_bank_reg #(.BITS(BANK_BITS)) u_bank (
        .clk (clk),
        .rst (rst),
        .we  (bank_we),
        .d   (wr_data[BANK_BITS-1:0]),
        .q   (bank_q)
    );

    busdec_rom_addr u_rom (
        .region   (region),
        .addr     (cpu_addr),
        .bank     (bank_q),
        .rom_addr (rom_addr)
    );

    always_comb begin
        rd_data = OPEN_BUS;
        if (acc.mem_rd && region != RGN_NONE) begin
            rd_data = mem_rdata;
        end else if (io_src.hit) begin
            if (io_src.is_key) rd_data = key_ports[io_src.idx*DW +: DW];
            else               rd_data = dip_banks[io_src.idx*DW +: DW];
        end
    end
endmodule

// File: rtl/busdec_chk.sv
module busdec_chk
    import busdec_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [CPU_AW-1:0]       cpu_addr,
    input logic                    mem_req,
    input logic                    io_req,
    input logic                    rd,
    input logic                    wr,
    input logic [DW-1:0]           wr_data,
    input logic [NUM_MEM_CS-1:0]   mem_cs,
    input logic [1:0]              snd_we,
    input logic [ROM_AW-1:0]       rom_addr,
    input logic [BANK_BITS-1:0]    bank_q
);
    logic bank_wr;
    assign bank_wr = io_req && !mem_req && wr && (cpu_addr[7:0] == 8'hA0);

    // R3
    bank_load_chk: assert property (@(posedge clk) disable iff (rst)
        bank_wr |=> (bank_q == $past(wr_data[BANK_BITS-1:0])));

    // R11
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bank_wr |=> $stable(bank_q));

    // R6
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mem_cs));

    // R6
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && !io_req && (rd || wr)) |-> (mem_cs == '0));

    // R9
    snd_we_chk: assert property (@(posedge clk) disable iff (rst)
        (snd_we != 2'b00) |-> (io_req && !mem_req && wr && cpu_addr[7:1] == 7'h20));

    // R2
    win_offset_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cs[1] |-> (rom_addr[WIN_BITS-1:0] == cpu_addr[WIN_BITS-1:0]
                       && rom_addr >= ROM_AW'(BANK_BASE)));
endmodule

bind cpu_bus_decoder busdec_chk u_chk (.*);

// File: tb/cpu_bus_decoder_tb.sv
module cpu_bus_decoder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        mem_req, io_req, rd, wr;
    logic [7:0]  wr_data, mem_rdata;
    logic [31:0] dip_banks;
    logic [23:0] key_ports;
    logic [7:0]  mem_cs;
    logic [1:0]  snd_we;
    logic [17:0] rom_addr;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cpu_bus_decoder u_dut (.*);

    // {addr, expected select, expected rom address} with bank 0
    localparam int NV = 18;
    localparam logic [41:0] VEC [NV] = '{
        {16'h0000, 8'h01, 18'h00000}, {16'h7FFF, 8'h01, 18'h07FFF},
        {16'h8000, 8'h02, 18'h10000}, {16'hBFFF, 8'h02, 18'h13FFF},
        {16'hC000, 8'h04, 18'h0},     {16'hC7FF, 8'h04, 18'h0},
        {16'hC800, 8'h08, 18'h0},     {16'hCBFF, 8'h08, 18'h0},
        {16'hCC00, 8'h10, 18'h0},     {16'hCFFF, 8'h10, 18'h0},
        {16'hD000, 8'h20, 18'h0},     {16'hD7FF, 8'h20, 18'h0},
        {16'hD800, 8'h40, 18'h0},     {16'hDFFF, 8'h40, 18'h0},
        {16'hE000, 8'h80, 18'h0},     {16'hE7FF, 8'h80, 18'h0},
        {16'hE800, 8'h00, 18'h0},     {16'hFFFF, 8'h00, 18'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        mem_req = 0; io_req = 0; rd = 0; wr = 0;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d,
                            input logic [1:0] exp_snd, input string req);
        @(negedge clk);
        idle(); io_req = 1; wr = 1; cpu_addr = a; wr_data = d;
        #1 check(req, 32'(snd_we), 32'(exp_snd));
        @(negedge clk);
        idle();
    endtask

    task automatic win_read(input logic [15:0] a, input logic [17:0] exp, input string req);
        @(negedge clk);
        idle(); mem_req = 1; rd = 1; cpu_addr = a;
        #1 check(req, 32'(rom_addr), 32'(exp));
    endtask

    task automatic io_read(input logic [15:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        idle(); io_req = 1; rd = 1; cpu_addr = a;
        #1 check(req, 32'(rd_data), 32'(exp));
        check("R6 io cycle selects no memory", 32'(mem_cs), 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(); cpu_addr = '0; wr_data = '0; mem_rdata = 8'h5A;
        dip_banks = 32'hD4C3B2A1; key_ports = 24'h9E8D7C;
        rst = 1;
        repeat (3) @(negedge clk);
        #1 check("R4 reset window base", 32'(rom_addr), 0);
        rst = 0;

        // R4: bank is 0 out of reset
        win_read(16'h8000, 18'h10000, "R4 bank zero after reset");

        // table walk: R1 R2 R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            logic [15:0] a;
            logic [7:0]  cs;
            logic [17:0] ra;
            {a, cs, ra} = VEC[i];
            @(negedge clk);
            idle(); mem_req = 1; rd = 1; cpu_addr = a;
            #1;
            check("R5/R6 select", 32'(mem_cs), 32'(cs));
            check("R1/R2 rom address", 32'(rom_addr), 32'(ra));
            check("R10 read data", 32'(rd_data), (cs != 0) ? 32'h5A : 32'hFF);
        end

        // R6: strobes inactive or both requests
        @(negedge clk); idle(); cpu_addr = 16'h0000; mem_req = 1;
        #1 check("R6 no rd/wr no select", 32'(mem_cs), 0);
        check("R10 idle bus reads FF", 32'(rd_data), 32'hFF);
        @(negedge clk); idle(); cpu_addr = 16'hC000; mem_req = 1; io_req = 1; rd = 1;
        #1 check("R6 both requests no select", 32'(mem_cs), 0);
        @(negedge clk); idle(); cpu_addr = 16'hD000; mem_req = 1; wr = 1;
        #1 check("R5 write selects tile-low", 32'(mem_cs), 32'h20);

        // R7 / R8 / R10 I/O reads
        io_read(16'h0000, 8'hA1, "R7 switch 0");
        io_read(16'h0020, 8'hB2, "R7 switch 1");
        io_read(16'h0040, 8'hC3, "R7 switch 2");
        io_read(16'h0060, 8'hD4, "R7 switch 3");
        io_read(16'h1220, 8'hB2, "R7 upper address ignored");
        io_read(16'h0080, 8'h7C, "R8 input 0");
        io_read(16'h00A0, 8'h8D, "R8 input 1");
        io_read(16'h00E0, 8'h9E, "R8 input 2");
        io_read(16'h0041, 8'hFF, "R10 unmapped port 41");
        io_read(16'h00C0, 8'hFF, "R10 unmapped port C0");

        // R9 synth writes
        io_write(16'h0040, 8'h12, 2'b01, "R9 synth address strobe");
        io_write(16'h0041, 8'h34, 2'b10, "R9 synth data strobe");

        // R3 bank loads and corner banks
        io_write(16'h00A0, 8'h05, 2'b00, "R3 bank write no synth");
        win_read(16'h8123, 18'h24123, "R3 bank 5");
        io_write(16'h00A0, 8'h07, 2'b00, "R3 bank write");
        win_read(16'hBFFF, 18'h2FFFF, "R3 bank 7 top");
        io_write(16'h3FA0, 8'hFA, 2'b00, "R3 upper bits write");
        win_read(16'h8000, 18'h18000, "R3 data bits 7:3 and addr 15:8 ignored");
        win_read(16'h0100, 18'h00100, "R1 fixed ROM unaffected by bank");

        // R11 writes that must not move the bank
        io_write(16'h0080, 8'h07, 2'b00, "R11 unmapped io write no synth");
        win_read(16'h8000, 18'h18000, "R11 io write to 80 keeps bank");
        @(negedge clk); idle(); mem_req = 1; wr = 1; cpu_addr = 16'h00A0; wr_data = 8'h07;
        #1 check("R11 memory write no synth", 32'(snd_we), 0);
        win_read(16'h8000, 18'h18000, "R11 memory write to A0 keeps bank");

        // R4 reset clears a non-zero bank
        @(negedge clk); idle(); rst = 1;
        @(negedge clk); rst = 0;
        win_read(16'h8000, 18'h10000, "R4 reset clears bank");

        @(negedge clk); idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule